// File: doc/BRIEF.md
# Transceiver Power-State and Reset Controller

This block turns two strap pins, an enable pin and a control register into the operating state of a radio transceiver. The state is one of battery saving, standby or run. The strap pins choose among four control modes. In the two slave-serial modes the enable pin gates power. In the two memory-boot modes the enable pin is set aside and only the register bits decide.

The block also handles a software reset command that arrives over the register write path. The command clears the control register, and the reset stays active until the next rising edge seen on the serial clock or on the chip select, whichever comes first. The block drives the transmit and receive antenna-switch levels, their output enables, and a status indicator that is high whenever the chip is awake.

Top module: `xcvr_pwr_ctrl`

## Requirements
- R1: `mode_o` equals the strap pins `mode_pins` = {high pin, low pin}. The codes are 0 = serial slave, 1 = serial slave test, 2 = memory boot and 3 = memory boot test.
- R2: In the serial modes (`mode_pins[1]`=0) the state is battery saving (`pstate_o`=0) when `en_pin` is low or control bit 7 is 0. It is standby (1) when the pin is high, bit 7 is 1 and bit 6 is 0. It is run (2) when the pin is high and bits 7 and 6 are both 1. The state is registered one cycle after its inputs.
- R3: In the memory-boot modes `en_pin` has no effect. Bit 7 = 0 gives battery saving, {bit 7, bit 6} = {1,0} gives standby and {1,1} gives run.
- R4: A write of exactly 0x55 to address 0x09 raises `swrst_o` on the next cycle and clears the control register at address 0x0A. A read of address 0x09 always returns 0x00.
- R5: While `swrst_o` is high, writes to the control register are ignored. `swrst_o` falls after the first rising edge on `sclk_i` or `cs_i` that comes after the command, counted after the input synchronizer. The state then stays battery saving until a new control value is written.
- R6: The software reset command is ignored in memory-boot mode (code 2) and accepted in memory-boot test mode (code 3).
- R7: `tx_sw_o` and `rx_sw_o` follow control bits 3 and 2 one cycle after the state leaves battery saving, and are low in battery saving. In the memory-boot modes they are low and their enables `tx_sw_oe` and `rx_sw_oe` are 0. In the serial modes the enables are 1.
- R8: `status_o` is 0 in battery saving and 1 in standby or run.
- R9: While `rst_n` is low, the control register reads 0, writes are ignored, the state is battery saving and `swrst_o` is 0.
- R10: A write to address 0x09 with any value other than 0x55 changes nothing.
- R11: A release edge that reaches the detector in the same cycle as a software reset command does not release that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| mode_pins | input | 2 | Control-mode strap pins {high, low} |
| en_pin | input | 1 | Enable pin |
| sclk_i | input | 1 | Serial clock line, used for software reset release |
| cs_i | input | 1 | Chip select line, used for software reset release |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data |
| mode_o | output | 2 | Decoded control mode |
| pstate_o | output | 2 | Power state: 0 saving, 1 standby, 2 run |
| status_o | output | 1 | High when awake |
| swrst_o | output | 1 | Software reset active |
| tx_sw_o | output | 1 | Transmit antenna-switch level |
| tx_sw_oe | output | 1 | Transmit antenna-switch drive enable |
| rx_sw_o | output | 1 | Receive antenna-switch level |
| rx_sw_oe | output | 1 | Receive antenna-switch drive enable |

## Verification
A software reset command and a release edge can fall in the same cycle. The same is true of a control write that lands while a reset is still pending. To provoke the first case, the bench raises the serial clock exactly the synchronizer depth ahead of the magic write, so that the synchronized rising edge and the write are both seen at one clock edge. The bench then judges the outcome at the ports. The reset must remain asserted with the line held high, the control register must read zero, and the reset must clear only on a later chip-select edge.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

   typedef enum logic [1:0] {
      PS_SAVE = 2'd0,
      PS_STBY = 2'd1,
      PS_RUN  = 2'd2
   } pstate_t;

   typedef enum logic [1:0] {
      CM_SER      = 2'd0,
      CM_SER_TEST = 2'd1,
      CM_MEM      = 2'd2,
      CM_MEM_TEST = 2'd3
   } cmode_t;

   function automatic logic is_mem_boot(input cmode_t m);
      return m[1];
   endfunction

endpackage

// File: rtl/xpc_edge_sync.sv
module xpc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   logic synced;
   logic prev_q;

   initial begin
      if (STAGES < 0 || STAGES > 4) $fatal(1, "xpc_edge_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i};
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   assign rise_o = synced & ~prev_q;

endmodule

// File: rtl/xpc_ctl_regs.sv
module xpc_ctl_regs #(
   parameter int             AW       = 8,
   parameter int             DW       = 8,
   parameter logic [AW-1:0]  CTL_ADDR = 8'h0A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] ctl_q,
   output logic [DW-1:0] rd_data
);
   logic ctl_hit;

   assign ctl_hit = wr_en && (wr_addr == CTL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (clear_i)  ctl_q <= '0;
      else if (ctl_hit)  ctl_q <= wr_data;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTL_ADDR) rd_data = ctl_q;
   end

   // R4: a clear request empties the control register by the next cycle
   p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (ctl_q == '0));

endmodule

// File: rtl/xpc_swreset.sv
module xpc_swreset
   import xpc_pkg::*;
#(
   parameter int             AW       = 8,
   parameter int             DW       = 8,
   parameter logic [AW-1:0]  RST_ADDR = 8'h09,
   parameter logic [DW-1:0]  MAGIC    = 8'h55,
   parameter int             SYNC     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cmode_t        mode_i,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          sclk_i,
   input  logic          cs_i,
   output logic          hit_o,
   output logic          active_o
);
   logic sclk_rise;
   logic cs_rise;
   logic release_edge;
   logic active_q;

   xpc_edge_sync #(.STAGES(SYNC)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .rise_o(sclk_rise));

   xpc_edge_sync #(.STAGES(SYNC)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cs_i), .rise_o(cs_rise));

   assign release_edge = sclk_rise | cs_rise;

   assign hit_o = wr_en && (wr_addr == RST_ADDR) && (wr_data == MAGIC)
                  && (mode_i != CM_MEM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         active_q <= 1'b0;
      else if (hit_o)                     active_q <= 1'b1;
      else if (active_q && release_edge)  active_q <= 1'b0;
   end

   assign active_o = active_q;

   // R4: an accepted command raises the reset on the next cycle
   p_magic_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RST_ADDR && wr_data == MAGIC && mode_i != CM_MEM)
      |=> active_q);

   // R6: plain memory-boot mode never starts a software reset
   p_mem_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && mode_i == CM_MEM) |=> !active_q);

   // R5: without a release edge a pending reset persists
   p_hold_without_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !sclk_rise && !cs_rise) |=> active_q);

endmodule

// File: rtl/xpc_power_fsm.sv
module xpc_power_fsm
   import xpc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  cmode_t  mode_i,
   input  logic    en_pin,
   input  logic    en_bit,
   input  logic    act_bit,
   output pstate_t state_q
);
   logic    awake;
   pstate_t state_d;

   always_comb begin
      if (is_mem_boot(mode_i)) awake = en_bit;
      else                     awake = en_pin & en_bit;
      if (!awake)       state_d = PS_SAVE;
      else if (act_bit) state_d = PS_RUN;
      else              state_d = PS_STBY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_SAVE;
      else        state_q <= state_d;
   end

   // R2: enable pin low in a serial mode forces battery saving
   p_pin_low_saves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[1] && !en_pin) |=> (state_q == PS_SAVE));

   // R3: memory-boot modes reach run from the bits alone
   p_mem_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[1] && en_bit && act_bit) |=> (state_q == PS_RUN));

   // R2: only the two legal codes of an awake state appear
   p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 2'd3);

endmodule

// File: rtl/xpc_antsw.sv
module xpc_antsw
   import xpc_pkg::*;
#(
   parameter int N = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cmode_t        mode_i,
   input  pstate_t       state_i,
   input  logic [N-1:0]  sel_i,
   output logic [N-1:0]  sw_o,
   output logic [N-1:0]  oe_o
);
   initial begin
      if (N < 1) $fatal(1, "xpc_antsw: N must be positive");
   end

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_sw
         logic sw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sw_q <= 1'b0;
            else        sw_q <= (state_i != PS_SAVE) && !is_mem_boot(mode_i) && sel_i[i];
         end
         assign sw_o[i] = sw_q;
         assign oe_o[i] = !is_mem_boot(mode_i);

         // R7: battery saving drives the switch low on the next cycle
         p_low_in_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (state_i == PS_SAVE) |=> !sw_q);
      end
   endgenerate

endmodule

// File: rtl/xcvr_pwr_ctrl.sv
module xcvr_pwr_ctrl
   import xpc_pkg::*;
#(
   parameter int            AW       = 8,
   parameter int            DW       = 8,
   parameter logic [AW-1:0] RST_ADDR = 8'h09,
   parameter logic [AW-1:0] CTL_ADDR = 8'h0A,
   parameter logic [DW-1:0] MAGIC    = 8'h55,
   parameter int            EN_BIT   = 7,
   parameter int            ACT_BIT  = 6,
   parameter int            TX_BIT   = 3,
   parameter int            RX_BIT   = 2,
   parameter int            SYNC     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_pins,
   input  logic          en_pin,
   input  logic          sclk_i,
   input  logic          cs_i,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [1:0]    mode_o,
   output logic [1:0]    pstate_o,
   output logic          status_o,
   output logic          swrst_o,
   output logic          tx_sw_o,
   output logic          tx_sw_oe,
   output logic          rx_sw_o,
   output logic          rx_sw_oe
);
   localparam int NSW = 2;

   initial begin
      if (DW <= EN_BIT || DW <= ACT_BIT || DW <= TX_BIT || DW <= RX_BIT)
         $fatal(1, "xcvr_pwr_ctrl: control bit outside data width");
      if (RST_ADDR == CTL_ADDR)
         $fatal(1, "xcvr_pwr_ctrl: reset and control addresses collide");
   end

   cmode_t          mode;
   pstate_t         state;
   logic [DW-1:0]   ctl_q;
   logic            sw_hit;
   logic            sw_active;
   logic [NSW-1:0]  sw_lvl;
   logic [NSW-1:0]  sw_oe;

   assign mode = cmode_t'(mode_pins);

   xpc_swreset #(
      .AW(AW), .DW(DW), .RST_ADDR(RST_ADDR), .MAGIC(MAGIC), .SYNC(SYNC)
   ) u_swrst (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sclk_i(sclk_i), .cs_i(cs_i),
      .hit_o(sw_hit), .active_o(sw_active));

   xpc_ctl_regs #(.AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .clear_i(sw_hit | sw_active),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .ctl_q(ctl_q), .rd_data(rd_data));

   xpc_power_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .en_pin(en_pin),
      .en_bit(ctl_q[EN_BIT]), .act_bit(ctl_q[ACT_BIT]), .state_q(state));

   xpc_antsw #(.N(NSW)) u_ant (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .state_i(state),
      .sel_i({ctl_q[RX_BIT], ctl_q[TX_BIT]}),
      .sw_o(sw_lvl), .oe_o(sw_oe));

   assign mode_o   = mode_pins;
   assign pstate_o = state;
   assign status_o = (state != PS_SAVE);
   assign swrst_o  = sw_active;
   assign tx_sw_o  = sw_lvl[0];
   assign rx_sw_o  = sw_lvl[1];
   assign tx_sw_oe = sw_oe[0];
   assign rx_sw_oe = sw_oe[1];

   // R8: a raised switch implies the indicator was high a cycle before
   p_switch_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sw_o || rx_sw_o) |-> $past(status_o));

   // R5: a pending software reset keeps the chip in battery saving
   p_swrst_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (swrst_o && $past(swrst_o)) |-> (pstate_o == 2'd0));

endmodule

// File: tb/xcvr_pwr_ctrl_test.sv
module xcvr_pwr_ctrl_test;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_pins = 2'd0;
   logic       en_pin = 1'b0;
   logic       sclk_i = 1'b0;
   logic       cs_i = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_addr = 8'h0A;
   logic [7:0] rd_data;
   logic [1:0] mode_o;
   logic [1:0] pstate_o;
   logic       status_o, swrst_o, tx_sw_o, tx_sw_oe, rx_sw_o, rx_sw_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xcvr_pwr_ctrl #(.SYNC(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .en_pin(en_pin),
      .sclk_i(sclk_i), .cs_i(cs_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mode_o(mode_o), .pstate_o(pstate_o), .status_o(status_o),
      .swrst_o(swrst_o), .tx_sw_o(tx_sw_o), .tx_sw_oe(tx_sw_oe),
      .rx_sw_o(rx_sw_o), .rx_sw_oe(rx_sw_oe));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      // R9: writes during hardware reset do nothing
      en_pin = 1'b1;
      idle(2);
      wr(8'h0A, 8'hFF);
      idle(2);
      rd(8'h0A, v);
      chk("R9 ctl in reset", v, 0);
      chk("R9 state in reset", pstate_o, 0);
      chk("R9 swrst in reset", swrst_o, 0);
      chk("R9 status in reset", status_o, 0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);

      // R1 R2 R3 R7 R8: sweep modes, pin and control bits
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 16; b++) begin
               logic [7:0] val;
               bit e7, a6, t3, r2, ser, awake;
               int est;
               e7 = b[3]; a6 = b[2]; t3 = b[1]; r2 = b[0];
               val = {e7, a6, 2'b00, t3, r2, 2'b00};
               mode_pins = 2'(m);
               en_pin = p[0];
               wr(8'h0A, val);
               idle(3);
               ser = (m < 2);
               awake = ser ? (p[0] && e7) : e7;
               est = !awake ? 0 : (a6 ? 2 : 1);
               chk("R1 mode", mode_o, m);
               chk(ser ? "R2 state" : "R3 state", pstate_o, est);
               chk("R8 status", status_o, (est != 0) ? 1 : 0);
               chk("R7 tx level", tx_sw_o, (ser && est != 0 && t3) ? 1 : 0);
               chk("R7 rx level", rx_sw_o, (ser && est != 0 && r2) ? 1 : 0);
               chk("R7 tx enable", tx_sw_oe, ser ? 1 : 0);
               chk("R7 rx enable", rx_sw_oe, ser ? 1 : 0);
            end
         end
      end

      // R7: switch output lags state by one cycle
      mode_pins = 2'd0; en_pin = 1'b1;
      wr(8'h0A, 8'h00);
      idle(3);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h0A; wr_data = 8'hC8;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 state lag", pstate_o, 0);
      @(negedge clk);
      chk("R7 state now run", pstate_o, 2);
      chk("R7 tx not yet", tx_sw_o, 0);
      @(negedge clk);
      chk("R7 tx follows", tx_sw_o, 1);

      // R4 R10: reset register reads zero; wrong byte ignored
      rd(8'h09, v);
      chk("R4 read reset reg", v, 0);
      wr(8'h09, 8'h54);
      idle(2);
      rd(8'h0A, v);
      chk("R10 ctl kept", v, 8'hC8);
      chk("R10 no swrst", swrst_o, 0);
      wr(8'h09, 8'hD5);
      idle(1);
      chk("R10 no swrst high bit", swrst_o, 0);

      // R4 R5: magic byte starts reset, held until edge
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h09; wr_data = 8'h55;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R4 swrst next cycle", swrst_o, 1);
      rd(8'h0A, v);
      chk("R4 ctl cleared", v, 0);
      rd(8'h09, v);
      chk("R4 reset reg reads zero", v, 0);
      idle(2);
      chk("R4 saving after swrst", pstate_o, 0);
      wr(8'h0A, 8'hC0);
      idle(4);
      chk("R5 held without edge", swrst_o, 1);
      rd(8'h0A, v);
      chk("R5 write ignored in reset", v, 0);
      cs_i = 1'b1;
      idle(SYNC + 2);
      chk("R5 released by cs", swrst_o, 0);
      chk("R5 still saving", pstate_o, 0);
      wr(8'h0A, 8'hC0);
      idle(2);
      chk("R5 run after command", pstate_o, 2);
      cs_i = 1'b0;
      idle(SYNC + 2);

      // R6: plain memory boot ignores command, test variant accepts
      mode_pins = 2'd2;
      wr(8'h09, 8'h55);
      idle(2);
      chk("R6 mem ignores", swrst_o, 0);
      rd(8'h0A, v);
      chk("R6 ctl kept", v, 8'hC0);
      mode_pins = 2'd3;
      wr(8'h09, 8'h55);
      idle(1);
      chk("R6 mem test accepts", swrst_o, 1);
      sclk_i = 1'b1;
      idle(SYNC + 2);
      chk("R5 released by sclk", swrst_o, 0);
      sclk_i = 1'b0;
      idle(SYNC + 2);

      // R11: release edge coincides with the command
      mode_pins = 2'd0;
      @(negedge clk) sclk_i = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h09; wr_data = 8'h55;
      @(negedge clk);
      wr_en = 1'b0;
      idle(4);
      chk("R11 reset survives edge", swrst_o, 1);
      rd(8'h0A, v);
      chk("R11 ctl cleared", v, 0);
      cs_i = 1'b1;
      idle(SYNC + 2);
      chk("R11 later cs releases", swrst_o, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule